// File: doc/BRIEF.md
# Serial Audio Transmit Channel

This block is the transmit half of a two-channel serial audio link that runs as the timing master. It reads 32-bit sample words from the read port of a show-ahead FIFO. It shifts them out most significant bit first on a single data line and drives the word-select line that marks the left and right halves of each frame. Bit timing comes from a one-cycle bit enable produced elsewhere, so the block runs entirely in the system clock domain.

The length of each half frame is programmed on its own, separate from the sample size. A half longer than the sample is padded with zeros, and a shorter half truncates the sample. The stereo control picks either a fresh word for each half or one word shown in both halves. Mute and stop silence the data line. Stop also blocks FIFO reads. A channel-clear input resets the state immediately and asks the FIFO to flush.

Top module: `aud_i2s_tx`

## Requirements
- R1: `width_code` sets the sample size, taken from the low bits of the FIFO word: 0 gives 8 bits, 1 gives 16, 3 gives 32, and 2 is handled as 16.
- R2: Out of reset, `ws` is 1 and `sd` is 0. `ws` then inverts on every (`half_len`+1)-th bit enable and never changes on a cycle without `bit_en`.
- R3: `sd` changes only on bit enables. The MSB of a half's sample appears on the first bit enable after the one that inverted `ws`, and the last bit of the half goes out on the enable that inverts `ws` again.
- R4: Bit position p of a half (0 = MSB slot) carries sample bit W-1-p when p < W and 0 otherwise, so a long half is zero-padded and a short one truncated.
- R5: With `mono_en` low, one word is popped for each half, with the left half (`ws`=0) first. The half that follows reset carries zeros.
- R6: With `mono_en` high, one word is popped at the start of each left half, and the same word is sent again in the following right half.
- R7: While `mute` is high, `sd` is 0. `ws` timing and FIFO reads continue unchanged.
- R8: While `halt` is high, `fifo_pop` stays low, `sd` is 0, no underrun is flagged, and `ws` keeps running.
- R9: If a word is needed while `fifo_empty` is high, that half (and, in mono, its right copy) is sent as zeros. `underrun` is then high for exactly the one cycle after that bit enable.
- R10: `chan_clr` at once (no clock needed) forces the reset state of R2 and drives `fifo_flush` high while held.
- R11: `fifo_pop` is high only in a cycle with `bit_en` high that ends a half and while the FIFO is not empty. `fifo_data` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle bit-clock enable |
| width_code | input | 2 | Sample size code |
| mono_en | input | 1 | 1 = same word in both halves |
| halt | input | 1 | Stop: no FIFO reads, silent output |
| chan_clr | input | 1 | Asynchronous channel clear |
| mute | input | 1 | Force data line to zero |
| half_len | input | HP_W (9) | Bits per half frame minus one |
| fifo_data | input | DATA_W (32) | Show-ahead FIFO head word |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Consume FIFO head this cycle |
| fifo_flush | output | 1 | Request to empty the FIFO |
| ws | output | 1 | Word select, 0 = left half |
| sd | output | 1 | Serial data, MSB first |
| underrun | output | 1 | One-cycle missing-sample pulse |

## Verification
The bench goes after the ends of the half-length range (4, 10, 17 and 32 bits) under all four width codes. A design that mishandles zero padding or truncation would then leak stale shift bits, or drop the MSBs of a short half. The one-bit lag between a `ws` edge and the MSB is checked on every bit enable, so an off-by-one in the shifter shows up as a rotated stream. Mono runs catch a right half that pops a second word or sends zeros. The FIFO is drained on purpose, which exposes a missing or stretched underrun pulse and a right half that repeats stale data after an underrun. Halt and an asynchronous clear in mid-half are also covered: a wrong design would keep reading the FIFO, or would only clear on the next clock.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

   typedef enum logic [1:0] {
      WID_8   = 2'd0,
      WID_16  = 2'd1,
      WID_16B = 2'd2,
      WID_32  = 2'd3
   } wid_code_e;

   localparam int unsigned BITS_NARROW = 8;
   localparam int unsigned BITS_MID    = 16;
   localparam int unsigned BITS_WIDE   = 32;

   // sample size selected by a width code; the spare code behaves as 16 bits
   function automatic int unsigned wid_bits(input logic [1:0] code);
      case (code)
         WID_8:   return BITS_NARROW;
         WID_32:  return BITS_WIDE;
         default: return BITS_MID;
      endcase
   endfunction

endpackage

// File: rtl/aud_ser_ws_timer.sv
module aud_ser_ws_timer #(
   parameter int unsigned HP_W = 9
) (
   input  logic            clk,
   input  logic            arst_n,
   input  logic            bit_en,
   input  logic [HP_W-1:0] half_len,
   output logic            ws,
   output logic            slot_end
);

   logic [HP_W-1:0] pos_q;

   // >= keeps the counter bounded if half_len shrinks mid-half
   assign slot_end = (pos_q >= half_len);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         pos_q <= '0;
         ws    <= 1'b1;
      end else if (bit_en) begin
         if (slot_end) begin
            pos_q <= '0;
            ws    <= ~ws;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   p_ws_on_bit_r2: assert property (@(posedge clk) disable iff (!arst_n)
      !bit_en |=> $stable(ws));

endmodule

// File: rtl/aud_ser_fetch.sv
module aud_ser_fetch #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              bit_en,
   input  logic              slot_end,
   input  logic              ws,
   input  logic              mono_en,
   input  logic              halt,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              fifo_pop,
   output logic [DATA_W-1:0] next_word,
   output logic              underrun
);

   logic [DATA_W-1:0] held_q;
   logic              need;
   logic              take;

   // current ws high means the next half is a left half
   assign need     = ~mono_en | ws;
   assign take     = bit_en & slot_end & need & ~halt & arst_n;
   assign fifo_pop = take & ~fifo_empty;

   always_comb begin
      if (halt || (need && fifo_empty))
         next_word = '0;
      else if (need)
         next_word = fifo_data;
      else
         next_word = held_q;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         held_q   <= '0;
         underrun <= 1'b0;
      end else begin
         underrun <= take & fifo_empty;
         if (bit_en && slot_end && need)
            held_q <= next_word;
      end
   end

   p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (!arst_n)
      fifo_pop |-> (!fifo_empty && bit_en));
   p_halt_no_pop_r8: assert property (@(posedge clk) disable iff (!arst_n)
      halt |-> !fifo_pop);
   p_mono_left_pop_r6: assert property (@(posedge clk) disable iff (!arst_n)
      (mono_en && fifo_pop) |=> !ws);
   p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!arst_n)
      underrun |-> $past(fifo_empty && bit_en));

endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              bit_en,
   input  logic              slot_end,
   input  logic [1:0]        width_code,
   input  logic [DATA_W-1:0] next_word,
   output logic              sd_q
);

   import aud_ser_pkg::*;

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] aligned;

   generate
      if (DATA_W == BITS_WIDE) begin : g_exact
         always_comb begin
            case (width_code)
               WID_8:   aligned = {next_word[BITS_NARROW-1:0], {(DATA_W-BITS_NARROW){1'b0}}};
               WID_32:  aligned = next_word;
               default: aligned = {next_word[BITS_MID-1:0], {(DATA_W-BITS_MID){1'b0}}};
            endcase
         end
      end else begin : g_wide
         always_comb begin
            case (width_code)
               WID_8:   aligned = {next_word[BITS_NARROW-1:0], {(DATA_W-BITS_NARROW){1'b0}}};
               WID_32:  aligned = {next_word[BITS_WIDE-1:0], {(DATA_W-BITS_WIDE){1'b0}}};
               default: aligned = {next_word[BITS_MID-1:0], {(DATA_W-BITS_MID){1'b0}}};
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         sh_q <= '0;
         sd_q <= 1'b0;
      end else if (bit_en) begin
         sd_q <= sh_q[DATA_W-1];
         sh_q <= slot_end ? aligned : {sh_q[DATA_W-2:0], 1'b0};
      end
   end

   p_sd_on_bit_r3: assert property (@(posedge clk) disable iff (!arst_n)
      !bit_en |=> $stable(sd_q));

endmodule

// File: rtl/aud_i2s_tx.sv
module aud_i2s_tx #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HP_W   = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [1:0]        width_code,
   input  logic              mono_en,
   input  logic              halt,
   input  logic              chan_clr,
   input  logic              mute,
   input  logic [HP_W-1:0]   half_len,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              fifo_pop,
   output logic              fifo_flush,
   output logic              ws,
   output logic              sd,
   output logic              underrun
);

   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("DATA_W must hold a 32-bit sample");
      end
      if (HP_W < 1) begin : g_bad_hp_w
         $error("HP_W must be at least 1");
      end
   endgenerate

   logic              arst_n;
   logic              slot_end;
   logic              sd_q;
   logic [DATA_W-1:0] next_word;

   assign arst_n     = rst_n & ~chan_clr;
   assign fifo_flush = chan_clr;
   assign sd         = sd_q & ~mute & ~halt;

   aud_ser_ws_timer #(.HP_W(HP_W)) u_timer (
      .clk      (clk),
      .arst_n   (arst_n),
      .bit_en   (bit_en),
      .half_len (half_len),
      .ws       (ws),
      .slot_end (slot_end)
   );

   aud_ser_fetch #(.DATA_W(DATA_W)) u_fetch (
      .clk        (clk),
      .arst_n     (arst_n),
      .bit_en     (bit_en),
      .slot_end   (slot_end),
      .ws         (ws),
      .mono_en    (mono_en),
      .halt       (halt),
      .fifo_data  (fifo_data),
      .fifo_empty (fifo_empty),
      .fifo_pop   (fifo_pop),
      .next_word  (next_word),
      .underrun   (underrun)
   );

   aud_ser_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .arst_n     (arst_n),
      .bit_en     (bit_en),
      .slot_end   (slot_end),
      .width_code (width_code),
      .next_word  (next_word),
      .sd_q       (sd_q)
   );

   p_mute_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mute || halt) |-> !sd);
   p_clr_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clr |-> (ws && !sd && !fifo_pop));

endmodule

// File: tb/aud_i2s_tx_test.sv
module aud_i2s_tx_test;

   localparam int CLK_PERIOD = 10;
   localparam int NW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic [1:0]  width_code = 2'd0;
   logic        mono_en = 1'b0;
   logic        halt = 1'b0;
   logic        chan_clr = 1'b0;
   logic        mute = 1'b0;
   logic [8:0]  half_len = 9'd7;
   logic [31:0] fifo_data;
   logic        fifo_empty;
   logic        fifo_pop;
   logic        fifo_flush;
   logic        ws;
   logic        sd;
   logic        underrun;

   logic [31:0] mem [NW];
   int          rd = 0;
   int          n_chk = 0;
   int          n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign fifo_data  = (rd < NW) ? mem[rd] : 32'h0;
   assign fifo_empty = (rd >= NW);

   always @(posedge clk) if (fifo_pop) rd <= rd + 1;

   aud_i2s_tx uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .width_code(width_code),
      .mono_en(mono_en), .halt(halt), .chan_clr(chan_clr), .mute(mute),
      .half_len(half_len), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
      .fifo_pop(fifo_pop), .fifo_flush(fifo_flush), .ws(ws), .sd(sd),
      .underrun(underrun)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(input logic [31:0] w, input logic [1:0] code, input int p);
      int wb;
      wb = (code == 2'd0) ? 8 : (code == 2'd3) ? 32 : 16;
      return (p < wb) ? w[wb-1-p] : 1'b0;
   endfunction

   task automatic step_event;
      @(negedge clk);
      bit_en = 1'b1;
   endtask

   task automatic run_cfg(input logic [1:0] code, input logic mo, input int hl,
                          input logic mu, input logic ht, input logic use_clr, input int seed);
      int h;
      int nslots;
      int nev;
      string sdtag;
      h = hl + 1;
      nslots = (mo ? 2 : 1) * NW + 2;
      nev = (1 + nslots) * h;
      sdtag = ht ? "R8 sd" : mu ? "R7 sd" : mo ? "R6 R4 sd" : "R1 R3 R4 R5 sd";
      if (use_clr) begin
         // dirty the state mid-half, then clear asynchronously
         for (int i = 0; i < 5; i++) begin
            step_event();
            @(negedge clk);
            bit_en = 1'b0;
         end
         #2;
         chan_clr = 1'b1;
         #1;
         chk("R10 async ws", ws, 1'b1);
         chk("R10 async sd", sd, 1'b0);
         chk("R10 flush", fifo_flush, 1'b1);
      end else begin
         @(negedge clk);
         rst_n = 1'b0;
      end
      width_code = code; mono_en = mo; half_len = hl[8:0]; mute = mu; halt = ht;
      for (int i = 0; i < NW; i++) mem[i] = (32'h9E3779B9 * (i + 1 + seed)) ^ 32'h5A0FC3A5;
      @(negedge clk);
      rd = 0;
      @(negedge clk);
      chk("R2 reset ws", ws, 1'b1);
      chk("R2 reset sd", sd, 1'b0);
      chk("R2 reset pop", fifo_pop, 1'b0);
      rst_n = 1'b1;
      chan_clr = 1'b0;
      @(negedge clk);
      chk("R10 flush released", fifo_flush, 1'b0);
      for (int k = 0; k < nev; k++) begin
         int jn, idxn, j, p, idx;
         logic bnd, need, ep, eu, es, ew;
         bnd  = ((k % h) == h - 1);
         jn   = (k + 1) / h;
         need = !mo || ((jn % 2) == 1);
         idxn = mo ? (jn - 1) / 2 : jn - 1;
         ep   = bnd && need && !ht && (idxn < NW);
         eu   = bnd && need && !ht && (idxn >= NW);
         j    = k / h;
         p    = k % h;
         idx  = mo ? (j - 1) / 2 : j - 1;
         ew   = (((k + 1) / h) % 2 == 0);
         if (j == 0 || mu || ht || idx >= NW) es = 1'b0;
         else es = exp_bit(mem[idx], code, p);
         step_event();
         #1;
         chk(ht ? "R8 pop" : mo ? "R6 pop" : "R11 R5 pop", fifo_pop, ep);
         @(negedge clk);
         bit_en = 1'b0;
         chk("R2 ws", ws, ew);
         chk(sdtag, sd, es);
         chk("R9 underrun", underrun, eu);
         @(negedge clk);
         chk("R9 underrun pulse width", underrun, 1'b0);
         chk("R3 sd steady", sd, es);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int hls [4] = '{3, 9, 16, 31};
      for (int c = 0; c < 4; c++)
         for (int m = 0; m < 2; m++)
            for (int q = 0; q < 4; q++)
               run_cfg(c[1:0], m[0], hls[q], 1'b0, 1'b0, 1'b0, c * 8 + m * 4 + q);
      run_cfg(2'd1, 1'b0, 15, 1'b1, 1'b0, 1'b0, 40);
      run_cfg(2'd0, 1'b1, 9, 1'b1, 1'b0, 1'b0, 41);
      run_cfg(2'd3, 1'b0, 31, 1'b0, 1'b1, 1'b0, 42);
      run_cfg(2'd1, 1'b1, 7, 1'b0, 1'b1, 1'b0, 43);
      run_cfg(2'd3, 1'b0, 9, 1'b0, 1'b0, 1'b1, 44);
      run_cfg(2'd0, 1'b1, 3, 1'b0, 1'b0, 1'b1, 45);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule